// File: doc/BRIEF.md
# Pipelined AXI4-Lite Memory Slave

This block is an on-chip RAM that answers on an AXI4-Lite bus. It is meant to hold program code and boot data in a small processor subsystem. The data width and the number of words are parameters. Writes can change single bytes of a word through the write strobes. A master that keeps its requests flowing gets one read and one write accepted on every clock.

Every ready signal the slave drives comes straight from a flop. A one-entry skid register on each request channel catches the beat that arrives in the cycle a stall begins, so no ready path runs combinationally back into the interconnect. The read side has three register stages: a registered address, the synchronous RAM read, and an extra output register that improves the clock rate of the inferred memory. When the read response is back-pressured, the whole read pipeline holds its contents.

Top module: `sram_axil_slave`

## Requirements
- R1: After reset, ARREADY, AWREADY and WREADY are 1, and RVALID and BVALID are 0.
- R2: Read latency with an idle pipeline and RREADY high. The read address is accepted at clock edge 1, and RVALID with its data first appears after clock edge 3.
- R3: With ARVALID held high and RREADY high, one read is accepted on every clock. Responses then come back on consecutive clocks, in request order, each holding the word last written at that index.
- R4: With AW and W presented together and BREADY high, one write is accepted on every clock. BVALID follows each acceptance by one edge.
- R5: WSTRB bit i enables byte lane i, which is data bits 8i+7 down to 8i. Lanes whose strobe bit is 0 keep their old contents, so a strobe of 0 leaves the word unchanged.
- R6: The word index is address bits [log2(DATA_W/8)+log2(DEPTH)-1 : log2(DATA_W/8)]. All lower and all higher address bits are ignored.
- R7: A request-channel ready falls only after a beat was accepted while the slave was stalled. At most one beat is parked per channel. With RREADY held low, exactly four reads are accepted before ARREADY drops.
- R8: RRESP and BRESP are always 2'b00 while their valid signal is high.
- R9: While RVALID is high and RREADY is low, RVALID and RDATA hold their values. No response is lost, duplicated or reordered across a stall.
- R10: A write is committed only once both its AW beat and its W beat have arrived, whichever arrives first. Exactly one B response is issued per committed write. A lone beat is parked and drops its own ready.
- R11: While BVALID is high and BREADY is low, BVALID holds. With BREADY held low, exactly two writes are accepted before AWREADY drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte lane enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |

## Verification
The bench builds the slave with 16-bit addresses, 32-bit data and 64 words. The small depth lets the bench preload and read back every word. It also makes aliasing through the ignored upper address bits easy to hit with short addresses. The random phase sends writes to the upper half of the memory and reads to the lower half while every valid and ready toggles at random. This exercises skid parking and pipeline stalls without read-after-write races.

// File: rtl/sram_axil_pkg.sv
package sram_axil_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  lanes);
    logic [31:0] res;
    res = old_w;
    for (int b = 0; b < 4; b++) if (lanes[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/sram_skid.sv
module sram_skid #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         park_q, park_d;
  logic [W-1:0] hold_q;
  logic         hold_en;

  // Park an accepted beat when the consumer is not taking it.
  always_comb begin
    park_d  = park_q;
    hold_en = 1'b0;
    if (!park_q) begin
      if (in_valid && !out_ready) begin
        park_d  = 1'b1;
        hold_en = 1'b1;
      end
    end else if (out_ready) begin
      park_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) park_q <= 1'b0;
    else        park_q <= park_d;
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= in_data;
  end

  assign in_ready  = !park_q;
  assign out_valid = park_q || in_valid;
  assign out_data  = park_q ? hold_q : in_data;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int NB    = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [NB-1:0]     wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_lanes[b]) mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/sram_axil_slave.sv
module sram_axil_slave
  import sram_axil_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp
);
  localparam int NB  = DATA_W / 8;
  localparam int OFF = $clog2(NB);
  localparam int IW  = $clog2(DEPTH);
  localparam int WW  = DATA_W + NB;

  // Address bits outside the word index are deliberately ignored.
  logic unused_addr_bits;
  assign unused_addr_bits = ^{s_awaddr[ADDR_W-1:OFF+IW], s_awaddr[OFF-1:0],
                              s_araddr[ADDR_W-1:OFF+IW], s_araddr[OFF-1:0]};

  // ---------------- write side ----------------
  logic          aw_v, w_v, commit;
  logic [IW-1:0] aw_idx;
  logic [WW-1:0] w_pay;
  logic          bvalid_q, bvalid_d;

  sram_skid #(.W(IW)) u_aw_skid (
    .clk(aclk), .rst_n(aresetn),
    .in_valid(s_awvalid), .in_ready(s_awready), .in_data(s_awaddr[OFF+IW-1:OFF]),
    .out_valid(aw_v), .out_ready(commit), .out_data(aw_idx)
  );

  sram_skid #(.W(WW)) u_w_skid (
    .clk(aclk), .rst_n(aresetn),
    .in_valid(s_wvalid), .in_ready(s_wready), .in_data({s_wstrb, s_wdata}),
    .out_valid(w_v), .out_ready(commit), .out_data(w_pay)
  );

  always_comb begin
    commit   = aw_v && w_v && (!bvalid_q || s_bready);
    bvalid_d = bvalid_q;
    if (commit)        bvalid_d = 1'b1;
    else if (s_bready) bvalid_d = 1'b0;
  end

  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) bvalid_q <= 1'b0;
    else          bvalid_q <= bvalid_d;
  end

  // ---------------- read side ----------------
  logic          ar_v, adv;
  logic [IW-1:0] ar_idx;
  logic          s1_v_q, s2_v_q, s3_v_q;
  logic          s1_v_d, s2_v_d, s3_v_d;
  logic [IW-1:0] s1_idx_q;
  logic [DATA_W-1:0] ram_q, rdata_q;

  sram_skid #(.W(IW)) u_ar_skid (
    .clk(aclk), .rst_n(aresetn),
    .in_valid(s_arvalid), .in_ready(s_arready), .in_data(s_araddr[OFF+IW-1:OFF]),
    .out_valid(ar_v), .out_ready(adv), .out_data(ar_idx)
  );

  always_comb begin
    adv    = !s3_v_q || s_rready;
    s1_v_d = adv ? ar_v   : s1_v_q;
    s2_v_d = adv ? s1_v_q : s2_v_q;
    s3_v_d = adv ? s2_v_q : s3_v_q;
  end

  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
      s3_v_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
      s3_v_q <= s3_v_d;
    end
  end

  always_ff @(posedge aclk) begin
    if (adv) begin
      s1_idx_q <= ar_idx;
      rdata_q  <= ram_q;
    end
  end

  sram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(aclk),
    .wr_en(commit), .wr_idx(aw_idx), .wr_lanes(w_pay[WW-1:DATA_W]), .wr_data(w_pay[DATA_W-1:0]),
    .rd_en(adv), .rd_idx(s1_idx_q), .rd_data(ram_q)
  );

  assign s_bvalid = bvalid_q;
  assign s_bresp  = RESP_OKAY;
  assign s_rvalid = s3_v_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = RESP_OKAY;
endmodule

// File: rtl/sram_axil_chk.sv
module sram_axil_chk #(
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp
);
  logic [3:0] rd_out, aw_out, w_out;
  logic ar_hs, r_hs, aw_hs, w_hs, b_hs;

  assign ar_hs = s_arvalid && s_arready;
  assign r_hs  = s_rvalid && s_rready;
  assign aw_hs = s_awvalid && s_awready;
  assign w_hs  = s_wvalid && s_wready;
  assign b_hs  = s_bvalid && s_bready;

  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      rd_out <= 4'd0;
      aw_out <= 4'd0;
      w_out  <= 4'd0;
    end else begin
      rd_out <= rd_out + 4'(ar_hs) - 4'(r_hs);
      aw_out <= aw_out + 4'(aw_hs) - 4'(b_hs);
      w_out  <= w_out + 4'(w_hs) - 4'(b_hs);
    end
  end

  p_rresp_okay_r8: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> s_rresp == 2'b00);
  p_bresp_okay_r8: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> s_bresp == 2'b00);
  p_rhold_r9: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  p_bhold_r11: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);
  p_arready_fall_r7: assert property (@(posedge aclk) disable iff (!aresetn)
    $fell(s_arready) |-> $past(s_arvalid));
  p_awready_fall_r7: assert property (@(posedge aclk) disable iff (!aresetn)
    $fell(s_awready) |-> $past(s_awvalid));
  p_wready_fall_r7: assert property (@(posedge aclk) disable iff (!aresetn)
    $fell(s_wready) |-> $past(s_wvalid));
  p_rd_inflight_r7: assert property (@(posedge aclk) disable iff (!aresetn)
    rd_out <= 4'd4);
  p_wr_inflight_r10: assert property (@(posedge aclk) disable iff (!aresetn)
    aw_out <= 4'd2 && w_out <= 4'd2);
  p_b_needs_both_r10: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> aw_out != 4'd0 && w_out != 4'd0);
endmodule

bind sram_axil_slave sram_axil_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sram_axil_slave.sv
module tb_sram_axil_slave;
  localparam int AW = 16, DW = 32, DEPTH = 64, NB = 4, OFF = 2, IW = 6;

  logic clk = 1'b0, rst_n;
  always #10 clk = ~clk;

  logic awvalid, awready, wvalid, wready, bvalid, bready, arvalid, arready, rvalid, rready;
  logic [AW-1:0] awaddr, araddr;
  logic [DW-1:0] wdata, rdata;
  logic [NB-1:0] wstrb;
  logic [1:0] bresp, rresp;

  sram_axil_slave #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .aclk(clk), .aresetn(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp)
  );

  logic [DW-1:0] model [DEPTH];
  logic [AW-1:0] arq[$], awq[$];
  logic [DW+NB-1:0] wq[$];
  logic [DW-1:0] rexp[$];
  int p_arv = 100, p_awv = 100, p_wv = 100, p_rr = 100, p_br = 100;
  int cyc = 0, n_chk = 0, n_fail = 0, acc_ar = 0, acc_aw = 0, acc_w = 0;
  int n_b = 0, n_r = 0, n_wr = 0, first_ar = -1, first_aw = -1, last_r = 0, last_b = 0;
  bit hs_ar = 0, hs_aw = 0, hs_w = 0, done = 0;
  logic [DW-1:0] last_rdata;

  function automatic logic [IW-1:0] widx(input logic [AW-1:0] a);
    return a[OFF+IW-1:OFF];
  endfunction

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [NB-1:0] s);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] s);
    awq.push_back(a);
    wq.push_back({s, d});
    model[widx(a)] = lanes(model[widx(a)], d, s);
    n_wr++;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    arq.push_back(a);
  endtask

  task automatic cycle();
    logic [DW-1:0] e;
    @(negedge clk);
    cyc++;
    if (hs_ar) void'(arq.pop_front());
    if (hs_aw) void'(awq.pop_front());
    if (hs_w)  void'(wq.pop_front());
    if (!arvalid || hs_ar) arvalid = arq.size() > 0 && ($urandom % 100) < p_arv;
    if (!awvalid || hs_aw) awvalid = awq.size() > 0 && ($urandom % 100) < p_awv;
    if (!wvalid || hs_w)   wvalid  = wq.size() > 0 && ($urandom % 100) < p_wv;
    if (arvalid) araddr = arq[0];
    if (awvalid) awaddr = awq[0];
    if (wvalid) {wstrb, wdata} = wq[0];
    rready = ($urandom % 100) < p_rr;
    bready = ($urandom % 100) < p_br;
    #1;
    hs_ar = arvalid && arready;
    hs_aw = awvalid && awready;
    hs_w  = wvalid && wready;
    if (hs_ar) begin
      rexp.push_back(model[widx(araddr)]);
      acc_ar++;
      if (first_ar < 0) first_ar = cyc;
    end
    if (hs_aw) begin
      acc_aw++;
      if (first_aw < 0) first_aw = cyc;
    end
    if (hs_w) acc_w++;
    if (rvalid && rready) begin
      if (rexp.size() == 0) check(1'b0, "R9 response without request", rdata, '0);
      else begin
        e = rexp.pop_front();
        check(rdata == e, "R3/R9 read data in order", rdata, e);
      end
      check(rresp == 2'b00, "R8 rresp", 32'(rresp), 0);
      last_rdata = rdata;
      n_r++;
      last_r = cyc;
    end
    if (bvalid && bready) begin
      check(bresp == 2'b00, "R8 bresp", 32'(bresp), 0);
      n_b++;
      last_b = cyc;
    end
  endtask

  task automatic run(input int n);
    repeat (n) cycle();
  endtask

  task automatic drain();
    int g = 0;
    p_arv = 100; p_awv = 100; p_wv = 100; p_rr = 100; p_br = 100;
    while ((arq.size() > 0 || awq.size() > 0 || wq.size() > 0 || rexp.size() > 0 ||
            arvalid || awvalid || wvalid || bvalid) && g < 5000) begin
      cycle();
      g++;
    end
    check(g < 5000, "R3 drain completes", 32'(g), 5000);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int b0, a0, r0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    {awvalid, wvalid, arvalid, rready, bready} = '0;
    awaddr = '0; araddr = '0; wdata = '0; wstrb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(arready == 1'b1, "R1 arready after reset", 32'(arready), 1);
    check(awready == 1'b1, "R1 awready after reset", 32'(awready), 1);
    check(wready == 1'b1, "R1 wready after reset", 32'(wready), 1);
    check(rvalid == 1'b0, "R1 rvalid after reset", 32'(rvalid), 0);
    check(bvalid == 1'b0, "R1 bvalid after reset", 32'(bvalid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < DEPTH; i++) wr(AW'(i * 4), $urandom, 4'hF);
    drain();
    check(n_b == DEPTH, "R4 preload B count", 32'(n_b), DEPTH);

    // R2: single read latency
    first_ar = -1;
    rd(16'h0008);
    drain();
    check(last_r - first_ar == 3, "R2 read latency", 32'(last_r - first_ar), 3);

    // R3: back-to-back reads
    first_ar = -1;
    for (int i = 0; i < 16; i++) rd(AW'(($urandom % DEPTH) * 4));
    drain();
    check(last_r - first_ar == 18, "R3 read throughput", 32'(last_r - first_ar), 18);

    // R4: back-to-back writes
    first_aw = -1;
    for (int i = 0; i < 16; i++) wr(AW'((i + 40) * 4), $urandom, 4'hF);
    drain();
    check(last_b - first_aw == 16, "R4 write throughput", 32'(last_b - first_aw), 16);
    for (int i = 0; i < 16; i++) rd(AW'((i + 40) * 4));
    drain();

    // R5: byte strobes
    wr(16'h0028, 32'h11223344, 4'hF);
    wr(16'h0028, 32'hAABBCCDD, 4'h5);
    drain();
    rd(16'h0028);
    drain();
    check(last_rdata == 32'h11BB33DD, "R5 lanes 0 and 2", last_rdata, 32'h11BB33DD);
    wr(16'h0028, 32'h0, 4'h0);
    drain();
    rd(16'h0028);
    drain();
    check(last_rdata == 32'h11BB33DD, "R5 zero strobe no change", last_rdata, 32'h11BB33DD);

    // R6: address decode
    wr(16'h0104, 32'hCAFEF00D, 4'hF);
    drain();
    rd(16'h0006);
    drain();
    check(last_rdata == 32'hCAFEF00D, "R6 low bits ignored", last_rdata, 32'hCAFEF00D);
    rd(16'hFF07);
    drain();
    check(last_rdata == 32'hCAFEF00D, "R6 high bits ignored", last_rdata, 32'hCAFEF00D);

    // R7 / R9: read stall fills pipeline and skid
    a0 = acc_ar; r0 = n_r;
    for (int i = 0; i < 6; i++) rd(AW'(i * 4));
    p_rr = 0;
    run(8);
    check(acc_ar - a0 == 4, "R7 reads accepted under stall", 32'(acc_ar - a0), 4);
    check(arready == 1'b0, "R7 arready dropped", 32'(arready), 0);
    check(rvalid == 1'b1, "R9 rvalid held", 32'(rvalid), 1);
    drain();
    check(n_r - r0 == 6, "R9 all stalled reads delivered", 32'(n_r - r0), 6);

    // R11: B stall
    a0 = acc_aw; b0 = n_b;
    for (int i = 0; i < 4; i++) wr(AW'((48 + i) * 4), $urandom, 4'hF);
    p_br = 0;
    run(6);
    check(acc_aw - a0 == 2, "R11 writes accepted under B stall", 32'(acc_aw - a0), 2);
    check(bvalid == 1'b1, "R11 bvalid held", 32'(bvalid), 1);
    check(awready == 1'b0, "R11 awready dropped", 32'(awready), 0);
    drain();
    check(n_b - b0 == 4, "R11 B count after stall", 32'(n_b - b0), 4);

    // R10: AW before W, then W before AW
    b0 = n_b;
    wr(16'h0050, 32'h5A5A0001, 4'hF);
    p_wv = 0;
    run(4);
    check(n_b == b0, "R10 no B without W", 32'(n_b), 32'(b0));
    check(bvalid == 1'b0, "R10 bvalid low without W", 32'(bvalid), 0);
    check(awready == 1'b0, "R10 lone AW parked", 32'(awready), 0);
    drain();
    check(n_b == b0 + 1, "R10 one B after W", 32'(n_b), 32'(b0 + 1));
    wr(16'h0054, 32'h5A5A0002, 4'hF);
    p_awv = 0;
    run(4);
    check(n_b == b0 + 1, "R10 no B without AW", 32'(n_b), 32'(b0 + 1));
    check(wready == 1'b0, "R10 lone W parked", 32'(wready), 0);
    drain();
    rd(16'h0050);
    rd(16'h0054);
    drain();
    check(last_rdata == 32'h5A5A0002, "R10 W-first write landed", last_rdata, 32'h5A5A0002);

    // Random mixed traffic: reads in lower half, writes in upper half
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2) rd(AW'((($urandom % 32) * 4) + ($urandom % 4)));
      else wr(AW'((32 + ($urandom % 32)) * 4), $urandom, NB'($urandom % 16));
    end
    p_arv = 70; p_awv = 70; p_wv = 70; p_rr = 70; p_br = 70;
    run(400);
    drain();
    for (int i = 32; i < DEPTH; i++) rd(AW'(i * 4));
    drain();
    check(n_b == n_wr, "R10 one B per write", 32'(n_b), 32'(n_wr));
    check(acc_aw == acc_w, "R10 AW and W counts match", 32'(acc_aw), 32'(acc_w));

    done = 1;
    summary();
    $finish;
  end
endmodule